// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block takes one 32-bit virtual address per request and decides how it is translated. It works out which of five fixed regions holds the address and applies the user-privilege check. It then chooses between a fixed translation and the result of a page-table lookup that the caller has already made. A translated request returns a physical address and a write-permission flag. A faulting request returns a fault code, a refill flag and the new contents of the three fault-capture registers: faulting address, context and entry-high. The caller loads these registers when `fault` is set.

The decision itself is combinational. All results are captured in one output register stage, so `outValid` pulses in the cycle after each cycle that has `reqValid` high. Requests may arrive back to back, one per cycle. The caller supplies the lookup status, the translated address and the writable bit for every request. These inputs are only used when the address is routed to the lookup.

Top module: `addrseg_decoder`

## Requirements
- R1: `outValid` is high in the cycle after each cycle with `reqValid` high, and low in the cycle after each cycle with `reqValid` low. It is low during reset and after reset.
- R2: When `userMode` is 1 and `vaddr` is 0x8000_0000 or above, the request faults with code 4 on a read or code 5 on a write (`isWrite`=1). The lookup inputs are ignored.
- R3: Addresses below 0x8000_0000 are routed to the lookup (`viaTlb`=1) when `errLevel` is 0. When `errLevel` is 1, the physical address equals the virtual address, `canWrite` is 1, no fault is raised and the lookup inputs are ignored.
- R4: Addresses 0x8000_0000 to 0x9FFF_FFFF map to `vaddr` − 0x8000_0000 with `canWrite`=1 and no fault, whatever the lookup status.
- R5: Addresses 0xA000_0000 to 0xBFFF_FFFF map to `vaddr` − 0xA000_0000 with `canWrite`=1 and no fault.
- R6: Addresses 0xC000_0000 and above are routed to the lookup. On a lookup hit (status 0), `physAddr` is `tlbPaddr` and `canWrite` is `tlbWritable`.
- R7: Lookup status codes are 0 hit, 1 no match, 2 entry invalid, 3 write to clean page. A lookup request with status 1 or 2 faults with code 2 on a read or code 3 on a write. `refill` is 1 only for status 1. Status 3 faults with code 1.
- R8: `segment` reports the region: 0 below 0x8000_0000, 1 for 0x8…/0x9…, 2 for 0xA…/0xB…, 3 for 0xC…/0xD…, 4 for 0xE… and above.
- R9: On a fault `badVaddr` equals the request's `vaddr`. Without a fault it is 0.
- R10: On a fault `contextNext` keeps bits 31..23 of `contextIn` and holds (`vaddr` >> 9) AND 0x007F_FFF0 in its lower bits. Without a fault it equals `contextIn`.
- R11: On a fault `entryHiNext` keeps bits 7..0 of `entryHiIn` and holds `vaddr` AND 0xFFFF_E000 above them, with bits 12..8 zero. Without a fault it equals `entryHiIn`.
- R12: A faulting result has `physAddr` 0 and `canWrite` 0. A non-faulting result has code 0 and `refill` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is presented this cycle |
| vaddr | input | 32 | Virtual address |
| isWrite | input | 1 | 1 for a store, 0 for a load |
| userMode | input | 1 | Request issued at user privilege |
| errLevel | input | 1 | Error-level status bit; 1 selects identity mapping of the low region |
| tlbStatus | input | 2 | Lookup result: 0 hit, 1 no match, 2 invalid, 3 clean page on write |
| tlbPaddr | input | 32 | Physical address from the lookup |
| tlbWritable | input | 1 | Lookup entry permits writes |
| contextIn | input | 32 | Current context register |
| entryHiIn | input | 32 | Current entry-high register |
| outValid | output | 1 | Result valid strobe |
| segment | output | 3 | Region code |
| viaTlb | output | 1 | Address was routed to the lookup |
| physAddr | output | 32 | Physical address (0 on fault) |
| canWrite | output | 1 | Write permitted |
| fault | output | 1 | Request faulted |
| faultCode | output | 3 | 0 none, 1 modify, 2 lookup load, 3 lookup store, 4 address load, 5 address store |
| refill | output | 1 | Fault came from a lookup miss |
| badVaddr | output | 32 | Faulting-address register value |
| contextNext | output | 32 | New context register value |
| entryHiNext | output | 32 | New entry-high register value |

## Verification
The bench aims at each region edge: 0x7FFF_FFFF, 0x8000_0000, 0x9FFF_FFFF, 0xA000_0000, 0xBFFF_FFFF, 0xC000_0000, 0xDFFF_FFFF and 0xE000_0000. A decoder comparing one address bit too few would put these addresses in the wrong region, or subtract the wrong base. It presents a failing lookup status where that status must be ignored: user-mode high addresses, error-level low addresses and the fixed kernel windows. A design that consulted the lookup there would report a lookup fault instead of an address error, or a fault where none is due. It checks the refill flag against the miss and invalid statuses, and the register updates against all-ones context and entry-high inputs. Clearing the wrong bits or shifting by the wrong amount then shows up in the captured values. Requests arrive back to back and with gaps, so a strobe that lingers or is dropped is caught.

// File: rtl/addrseg_pkg.sv
package addrseg_pkg;

  localparam int ADDR_W   = 32;
  localparam int ASID_W   = 8;
  localparam int REGION_W = 3;

  localparam logic [ADDR_W-1:0] KSEG0_BASE    = 32'h8000_0000;
  localparam logic [ADDR_W-1:0] KSEG1_BASE    = 32'hA000_0000;
  localparam logic [ADDR_W-1:0] CTX_KEEP_MASK = 32'hFF80_0000;
  localparam logic [ADDR_W-1:0] CTX_VPN_MASK  = 32'h007F_FFF0;
  localparam int                CTX_SHIFT     = 9;
  localparam logic [ADDR_W-1:0] EHI_VPN_MASK  = 32'hFFFF_E000;
  localparam logic [ADDR_W-1:0] EHI_ASID_MASK = {{(ADDR_W-ASID_W){1'b0}}, {ASID_W{1'b1}}};

  typedef enum logic [1:0] {
    TLB_HIT     = 2'd0,
    TLB_NOMATCH = 2'd1,
    TLB_INVALID = 2'd2,
    TLB_CLEAN   = 2'd3
  } tlbStatus_e;

  typedef enum logic [2:0] {
    SEG_USER  = 3'd0,
    SEG_KDIR  = 3'd1,
    SEG_KUNC  = 3'd2,
    SEG_KMAP2 = 3'd3,
    SEG_KMAP3 = 3'd4
  } segment_e;

  typedef enum logic [2:0] {
    FC_NONE       = 3'd0,
    FC_MODIFY     = 3'd1,
    FC_TLB_LOAD   = 3'd2,
    FC_TLB_STORE  = 3'd3,
    FC_ADDR_LOAD  = 3'd4,
    FC_ADDR_STORE = 3'd5
  } faultCode_e;

  typedef enum logic [1:0] {
    MAP_IDENTITY = 2'd0,
    MAP_KDIR     = 2'd1,
    MAP_KUNC     = 2'd2,
    MAP_LOOKUP   = 2'd3
  } mapSel_e;

  typedef struct packed {
    logic       load;
    logic       fault;
    logic       refill;
    logic       viaTlb;
    logic       writeOk;
    mapSel_e    mapSel;
    faultCode_e code;
    segment_e   seg;
  } ctrlStrobe_t;

endpackage

// File: rtl/addrseg_ctrl.sv
module addrseg_ctrl
  import addrseg_pkg::*;
#(
  parameter int TOP_BITS = REGION_W
) (
  input  logic                reqValid,
  input  logic [TOP_BITS-1:0] vaddrTop,
  input  logic                isWrite,
  input  logic                userMode,
  input  logic                errLevel,
  input  logic [1:0]          tlbStatus,
  input  logic                tlbWritable,
  output ctrlStrobe_t         strobe
);

  localparam int MSB = TOP_BITS - 1;

  segment_e   seg;
  logic       badAddr;
  logic       useLookup;
  tlbStatus_e status;
  faultCode_e code;

  assign status = tlbStatus_e'(tlbStatus);

  always_comb begin
    if (!vaddrTop[MSB]) begin
      seg = SEG_USER;
    end else begin
      unique case (vaddrTop[MSB-1 -: 2])
        2'b00:   seg = SEG_KDIR;
        2'b01:   seg = SEG_KUNC;
        2'b10:   seg = SEG_KMAP2;
        default: seg = SEG_KMAP3;
      endcase
    end
  end

  assign badAddr = userMode && vaddrTop[MSB];

  always_comb begin
    useLookup = 1'b0;
    if (!badAddr) begin
      unique case (seg)
        SEG_USER:             useLookup = !errLevel;
        SEG_KMAP2, SEG_KMAP3: useLookup = 1'b1;
        default:              useLookup = 1'b0;
      endcase
    end
  end

  always_comb begin
    code = FC_NONE;
    if (badAddr) begin
      code = isWrite ? FC_ADDR_STORE : FC_ADDR_LOAD;
    end else if (useLookup) begin
      unique case (status)
        TLB_NOMATCH, TLB_INVALID: code = isWrite ? FC_TLB_STORE : FC_TLB_LOAD;
        TLB_CLEAN:                code = FC_MODIFY;
        default:                  code = FC_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = reqValid;
    strobe.code    = code;
    strobe.fault   = (code != FC_NONE);
    strobe.refill  = useLookup && (status == TLB_NOMATCH);
    strobe.viaTlb  = useLookup;
    strobe.writeOk = useLookup ? tlbWritable : 1'b1;
    strobe.seg     = seg;
    if (useLookup)              strobe.mapSel = MAP_LOOKUP;
    else if (seg == SEG_KDIR)   strobe.mapSel = MAP_KDIR;
    else if (seg == SEG_KUNC)   strobe.mapSel = MAP_KUNC;
    else                        strobe.mapSel = MAP_IDENTITY;
  end

endmodule

// File: rtl/addrseg_dp.sv
module addrseg_dp
  import addrseg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] tlbPaddr,
  input  logic [AW-1:0] contextIn,
  input  logic [AW-1:0] entryHiIn,
  output logic          outValid,
  output logic [2:0]    segment,
  output logic          viaTlb,
  output logic [AW-1:0] physAddr,
  output logic          canWrite,
  output logic          fault,
  output logic [2:0]    faultCode,
  output logic          refill,
  output logic [AW-1:0] badVaddr,
  output logic [AW-1:0] contextNext,
  output logic [AW-1:0] entryHiNext
);

  logic [AW-1:0] physComb;
  logic [AW-1:0] badComb;
  logic [AW-1:0] ctxComb;
  logic [AW-1:0] ehiComb;

  always_comb begin
    unique case (strobe.mapSel)
      MAP_KDIR:   physComb = vaddr - KSEG0_BASE;
      MAP_KUNC:   physComb = vaddr - KSEG1_BASE;
      MAP_LOOKUP: physComb = tlbPaddr;
      default:    physComb = vaddr;
    endcase
    if (strobe.fault) physComb = '0;
  end

  always_comb begin
    if (strobe.fault) begin
      badComb = vaddr;
      ctxComb = (contextIn & CTX_KEEP_MASK) | ((vaddr >> CTX_SHIFT) & CTX_VPN_MASK);
      ehiComb = (entryHiIn & EHI_ASID_MASK) | (vaddr & EHI_VPN_MASK);
    end else begin
      badComb = '0;
      ctxComb = contextIn;
      ehiComb = entryHiIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.load;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segment     <= '0;
      viaTlb      <= 1'b0;
      physAddr    <= '0;
      canWrite    <= 1'b0;
      fault       <= 1'b0;
      faultCode   <= '0;
      refill      <= 1'b0;
      badVaddr    <= '0;
      contextNext <= '0;
      entryHiNext <= '0;
    end else if (strobe.load) begin
      segment     <= strobe.seg;
      viaTlb      <= strobe.viaTlb;
      physAddr    <= physComb;
      canWrite    <= strobe.writeOk && !strobe.fault;
      fault       <= strobe.fault;
      faultCode   <= strobe.code;
      refill      <= strobe.refill;
      badVaddr    <= badComb;
      contextNext <= ctxComb;
      entryHiNext <= ehiComb;
    end
  end

endmodule

// File: rtl/addrseg_decoder.sv
module addrseg_decoder
  import addrseg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [AW-1:0] vaddr,
  input  logic          isWrite,
  input  logic          userMode,
  input  logic          errLevel,
  input  logic [1:0]    tlbStatus,
  input  logic [AW-1:0] tlbPaddr,
  input  logic          tlbWritable,
  input  logic [AW-1:0] contextIn,
  input  logic [AW-1:0] entryHiIn,
  output logic          outValid,
  output logic [2:0]    segment,
  output logic          viaTlb,
  output logic [AW-1:0] physAddr,
  output logic          canWrite,
  output logic          fault,
  output logic [2:0]    faultCode,
  output logic          refill,
  output logic [AW-1:0] badVaddr,
  output logic [AW-1:0] contextNext,
  output logic [AW-1:0] entryHiNext
);

  ctrlStrobe_t strobe;

  addrseg_ctrl #(.TOP_BITS(REGION_W)) u_ctrl (
    .reqValid    (reqValid),
    .vaddrTop    (vaddr[AW-1 -: REGION_W]),
    .isWrite     (isWrite),
    .userMode    (userMode),
    .errLevel    (errLevel),
    .tlbStatus   (tlbStatus),
    .tlbWritable (tlbWritable),
    .strobe      (strobe)
  );

  addrseg_dp #(.AW(AW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .vaddr       (vaddr),
    .tlbPaddr    (tlbPaddr),
    .contextIn   (contextIn),
    .entryHiIn   (entryHiIn),
    .outValid    (outValid),
    .segment     (segment),
    .viaTlb      (viaTlb),
    .physAddr    (physAddr),
    .canWrite    (canWrite),
    .fault       (fault),
    .faultCode   (faultCode),
    .refill      (refill),
    .badVaddr    (badVaddr),
    .contextNext (contextNext),
    .entryHiNext (entryHiNext)
  );

endmodule

// File: rtl/addrseg_decoder_chk.sv
module addrseg_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] vaddr,
  input logic        userMode,
  input logic        errLevel,
  input logic [31:0] contextIn,
  input logic [31:0] entryHiIn,
  input logic        outValid,
  input logic [31:0] physAddr,
  input logic        canWrite,
  input logic        fault,
  input logic [2:0]  faultCode,
  input logic        refill,
  input logic [31:0] badVaddr,
  input logic [31:0] contextNext,
  input logic [31:0] entryHiNext
);

  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  p_user_high_adderr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && userMode && vaddr[31]) |=> (fault && (faultCode == 3'd4 || faultCode == 3'd5)));

  p_erl_identity_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !vaddr[31] && errLevel) |=> (!fault && physAddr == $past(vaddr)));

  p_kunc_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !userMode && vaddr[31:29] == 3'b101) |=>
      (!fault && physAddr == {3'b000, $past(vaddr[28:0])}));

  p_refill_is_lookup_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && refill) |-> (fault && (faultCode == 3'd2 || faultCode == 3'd3)));

  p_badvaddr_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (fault ? (badVaddr == $past(vaddr)) : (badVaddr == 32'h0)));

  p_context_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (contextNext[31:23] == $past(contextIn[31:23])));

  p_entryhi_asid_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (entryHiNext[7:0] == $past(entryHiIn[7:0])));

  p_fault_no_phys_r12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fault) |-> (physAddr == 32'h0 && !canWrite));

endmodule

bind addrseg_decoder addrseg_decoder_chk u_chk (.*);

// File: tb/addrseg_decoder_tb.sv
module addrseg_decoder_tb;

  typedef struct {
    logic [2:0]  seg;
    logic        viaTlb;
    logic [31:0] phys;
    logic        canWrite;
    logic        fault;
    logic [2:0]  code;
    logic        refill;
    logic [31:0] bad;
    logic [31:0] ctx;
    logic [31:0] ehi;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        isWrite = 1'b0;
  logic        userMode = 1'b0;
  logic        errLevel = 1'b0;
  logic [1:0]  tlbStatus = '0;
  logic [31:0] tlbPaddr = '0;
  logic        tlbWritable = 1'b0;
  logic [31:0] contextIn = '0;
  logic [31:0] entryHiIn = '0;
  logic        outValid;
  logic [2:0]  segment;
  logic        viaTlb;
  logic [31:0] physAddr;
  logic        canWrite;
  logic        fault;
  logic [2:0]  faultCode;
  logic        refill;
  logic [31:0] badVaddr;
  logic [31:0] contextNext;
  logic [31:0] entryHiNext;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  addrseg_decoder u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic expItem_t model(input logic [31:0] va, input bit wr, input bit um, input bit erl,
                                     input logic [1:0] st, input logic [31:0] pa, input bit we,
                                     input logic [31:0] ctx, input logic [31:0] ehi);
    expItem_t e;
    bit lookup = 1'b0;
    e.fault = 1'b0; e.code = 3'd0; e.refill = 1'b0; e.viaTlb = 1'b0; e.canWrite = 1'b1; e.phys = va;
    if (va < 32'h8000_0000)      e.seg = 3'd0;
    else if (va < 32'hA000_0000) e.seg = 3'd1;
    else if (va < 32'hC000_0000) e.seg = 3'd2;
    else if (va < 32'hE000_0000) e.seg = 3'd3;
    else                         e.seg = 3'd4;
    if (um && va > 32'h7FFF_FFFF) begin
      e.fault = 1'b1; e.code = wr ? 3'd5 : 3'd4;
    end else if (va < 32'h8000_0000) begin
      lookup = !erl;
    end else if (va < 32'hA000_0000) begin
      e.phys = va - 32'h8000_0000;
    end else if (va < 32'hC000_0000) begin
      e.phys = va - 32'hA000_0000;
    end else begin
      lookup = 1'b1;
    end
    if (lookup) begin
      e.viaTlb = 1'b1;
      case (st)
        2'd0: begin e.phys = pa; e.canWrite = we; end
        2'd1: begin e.fault = 1'b1; e.code = wr ? 3'd3 : 3'd2; e.refill = 1'b1; end
        2'd2: begin e.fault = 1'b1; e.code = wr ? 3'd3 : 3'd2; end
        default: begin e.fault = 1'b1; e.code = 3'd1; end
      endcase
    end
    if (e.fault) begin
      e.phys = 32'h0; e.canWrite = 1'b0; e.bad = va;
      e.ctx = {ctx[31:23], va[31:13], 4'h0};
      e.ehi = {va[31:13], 5'h0, ehi[7:0]};
    end else begin
      e.bad = 32'h0; e.ctx = ctx; e.ehi = ehi;
    end
    return e;
  endfunction

  task automatic send(input logic [31:0] va, input bit wr, input bit um, input bit erl,
                      input logic [1:0] st, input logic [31:0] pa, input bit we,
                      input logic [31:0] ctx, input logic [31:0] ehi);
    @(negedge clk);
    vaddr = va; isWrite = wr; userMode = um; errLevel = erl; tlbStatus = st;
    tlbPaddr = pa; tlbWritable = we; contextIn = ctx; entryHiIn = ehi; reqValid = 1'b1;
    expQ.push_back(model(va, wr, um, erl, st, pa, we, ctx, ehi));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      vaddr = 32'hDEAD_BEEF;
      tlbStatus = 2'd1;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1 strobe without request", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(segment === e.seg, "R8 segment", {29'd0, segment}, {29'd0, e.seg});
          check(viaTlb === e.viaTlb, "R3/R6 viaTlb", {31'd0, viaTlb}, {31'd0, e.viaTlb});
          check(physAddr === e.phys, "R3/R4/R5/R6/R12 physAddr", physAddr, e.phys);
          check(canWrite === e.canWrite, "R6/R12 canWrite", {31'd0, canWrite}, {31'd0, e.canWrite});
          check(fault === e.fault, "R2/R7 fault", {31'd0, fault}, {31'd0, e.fault});
          check(faultCode === e.code, "R2/R7 faultCode", {29'd0, faultCode}, {29'd0, e.code});
          check(refill === e.refill, "R7 refill", {31'd0, refill}, {31'd0, e.refill});
          check(badVaddr === e.bad, "R9 badVaddr", badVaddr, e.bad);
          check(contextNext === e.ctx, "R10 contextNext", contextNext, e.ctx);
          check(entryHiNext === e.ehi, "R11 entryHiNext", entryHiNext, e.ehi);
        end
      end else if (expQ.size() != 0 && !reqValid) begin
        check(1'b0, "R1 missing strobe", 32'd0, 32'd1);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid === 1'b0, "R1 reset outValid", {31'd0, outValid}, 32'd0);
    check(fault === 1'b0, "R12 reset fault", {31'd0, fault}, 32'd0);
    rstN = 1'b1;
    idle(2);
    check(outValid === 1'b0, "R1 idle after reset", {31'd0, outValid}, 32'd0);

    // R4: kseg0 reads ignore a failing lookup
    send(32'h8000_1234, 0, 0, 0, 2'd1, 32'h0, 0, 32'h1234_5678, 32'h0000_00AB);
    // R5: kseg1 write
    send(32'hA012_3454, 1, 0, 0, 2'd3, 32'h0, 0, 32'h0, 32'h0);
    // R6: useg lookup hit, writable and not
    send(32'h0040_0000, 1, 1, 0, 2'd0, 32'h1F00_0000, 1, 32'h0, 32'h0);
    send(32'h0040_0004, 0, 0, 0, 2'd0, 32'h1F00_0004, 0, 32'h0, 32'h0);
    // R3: error level identity, lookup miss ignored
    send(32'h7FFF_FFFF, 1, 0, 1, 2'd1, 32'h0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R2: user high addresses, lookup hit ignored
    send(32'h8000_0000, 0, 1, 0, 2'd0, 32'h5555_5555, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send(32'hFFFF_FFFF, 1, 1, 1, 2'd0, 32'h5555_5555, 1, 32'h0, 32'h0000_0042);
    // R7: miss with refill, invalid, clean page
    send(32'h1234_5678, 0, 1, 0, 2'd1, 32'h0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send(32'hC000_0000, 1, 0, 0, 2'd2, 32'h0, 0, 32'hA5A5_A5A5, 32'h5A5A_5A5A);
    send(32'hE000_1FFF, 1, 0, 0, 2'd3, 32'h0, 1, 32'h0, 32'h0000_00FF);
    send(32'h0000_0000, 1, 0, 0, 2'd1, 32'h0, 0, 32'h0, 32'h0);
    idle(1);
    // R8: region edges
    send(32'h7FFF_FFFF, 0, 0, 0, 2'd0, 32'h0ABC_0000, 1, 32'h0, 32'h0);
    send(32'h9FFF_FFFF, 0, 0, 0, 2'd1, 32'h0, 0, 32'h0, 32'h0);
    send(32'hA000_0000, 1, 0, 0, 2'd1, 32'h0, 0, 32'h0, 32'h0);
    send(32'hBFFF_FFFF, 0, 0, 1, 2'd2, 32'h0, 0, 32'h0, 32'h0);
    send(32'hDFFF_FFFF, 0, 0, 0, 2'd0, 32'h0777_0000, 0, 32'h0, 32'h0);
    send(32'hE000_0000, 0, 0, 0, 2'd0, 32'h0888_0000, 1, 32'h0, 32'h0);
    send(32'hC000_0000, 1, 0, 1, 2'd0, 32'h0999_0000, 1, 32'h0, 32'h0);
    idle(3);
    check(outValid === 1'b0, "R1 quiet after gap", {31'd0, outValid}, 32'd0);
    check(expQ.size() == 0, "R1 all results seen", expQ.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule